// File: doc/BRIEF.md
# Single-Vector Interrupt Entry Unit

This unit is the interrupt-control slice of a small 32-bit soft processor. Thirty-two request lines are latched into a sticky pending register. A per-line enable mask and one global enable bit qualify that register. When the global enable is set and at least one pending line is also enabled, the unit raises a take pulse. With the pulse it gives the pipeline a redirect target and the value to store as the exception return address. That value is the next-instruction address from the pipeline.

Every line enters the same vector, which sits at a fixed offset of 0xC0 from a software-programmed exception base. Entry copies the global enable into a saved-enable bit and then clears the global enable, so a handler cannot be interrupted. The handler reads the pending and mask registers to decide which line to serve. It clears pending bits by writing ones to them. A return strobe restores the global enable from the saved bit, and the unit supplies the recorded return address as the jump target.

Top module: `irq_entry_unit`

## Requirements
- R1: A high request line sets its pending bit at the next clock edge, and the bit stays set after the line drops. The pending register reads at CSR select 0, with bit i belonging to line i.
- R2: A CSR write to select 0 clears exactly the pending bits whose write-data bit is 1, and leaves the bits written as 0 unchanged. If a line is high in the same cycle that its bit is written with 1, the bit stays set.
- R3: `take_irq` is high in a cycle exactly when the global enable is set and the bitwise AND of pending and mask is nonzero. A pending line whose mask bit is 0 never causes a take.
- R4: In the cycle after a take, the global enable reads 0 and the saved-enable bit reads 1. The control register is at CSR select 2, with bit 0 the global enable and bit 1 the saved enable.
- R5: The exception-base register is at CSR select 3, and its low 8 bits always read 0 whatever is written. `take_target` equals the base plus 0xC0.
- R6: During a take, `epc_value` equals `next_pc`. From the cycle after the take, `ret_target` holds that address.
- R7: While the global enable is clear, no take occurs, even when enabled lines are pending. A take lasts one cycle.
- R8: `eret` copies the saved-enable bit into the global enable at the next edge and leaves the saved-enable bit unchanged. If a take happens in the same cycle, the take has priority.
- R9: After reset, pending, mask, global enable, saved enable, base and the return address are all 0.
- R10: The mask register, at CSR select 1, reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 32 | Interrupt request lines, level-sampled |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR select: 0 pending, 1 mask, 2 control, 3 base |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_sel` (combinational) |
| next_pc | input | 32 | Address of the next instruction, from the pipeline |
| eret | input | 1 | Return-from-exception strobe |
| take_irq | output | 1 | Interrupt taken this cycle |
| take_target | output | 32 | Redirect PC: base + 0xC0 |
| epc_value | output | 32 | Value to write into the exception-address register |
| ret_target | output | 32 | Recorded return address for `eret` |

## Verification
`take_irq`, `take_target`, `epc_value` and `csr_rdata` are combinational. They are due in the same cycle as the register state that drives them, so the bench checks them 1 ns after it changes an input on the falling edge. Pending, mask, control and base updates, and the entry and return effects on the enables and `ret_target`, appear one rising edge after the stimulus. The bench therefore reads them at the following falling edge. The take pulse is checked both in the cycle where it is expected and in the cycle after it, which confirms that it lasts exactly one cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_BASE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic gie;
        logic saved;
    } en_state_t;

    localparam int CTRL_GIE_BIT   = 0;
    localparam int CTRL_SAVED_BIT = 1;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic                 clr_we,
    input  logic [NUM_LINES-1:0] clr_bits,
    output logic [NUM_LINES-1:0] pend
);

    typedef struct packed {
        logic [NUM_LINES-1:0] bits;
    } pend_state_t;

    pend_state_t st_d, st_q;

    // One cell per line: a high request sets the bit; a W1C write clears it,
    // except that a request in the same cycle wins.
    logic [NUM_LINES-1:0] cell_next;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cell
        always_comb begin
            cell_next[i] = st_q.bits[i];
            if (clr_we && clr_bits[i]) begin
                cell_next[i] = 1'b0;
            end
            if (req[i]) begin
                cell_next[i] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = cell_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.bits;

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] mask,
    output logic                 hit_any
);

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.en = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask    = st_q.en;
    assign hit_any = |(pend & st_q.en);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_any,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wdata,
    input  logic       eret,
    output logic       take,
    output logic       gie,
    output logic       saved
);

    en_state_t st_d, st_q;
    logic      take_w;

    assign take_w = st_q.gie && hit_any;

    // Priority: entry, then return, then software write.
    always_comb begin
        st_d = st_q;
        if (take_w) begin
            st_d.saved = st_q.gie;
            st_d.gie   = 1'b0;
        end else if (eret) begin
            st_d.gie = st_q.saved;
        end else if (ctrl_we) begin
            st_d.gie   = ctrl_wdata[CTRL_GIE_BIT];
            st_d.saved = ctrl_wdata[CTRL_SAVED_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take  = take_w;
    assign gie   = st_q.gie;
    assign saved = st_q.saved;

endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen #(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 8,
    parameter int VEC_OFFSET = 'hC0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       base_we,
    input  logic [XLEN-ALIGN_BITS-1:0] base_hi_wdata,
    input  logic                       take,
    input  logic [XLEN-1:0]            next_pc,
    output logic [XLEN-1:0]            base,
    output logic [XLEN-1:0]            target,
    output logic [XLEN-1:0]            epc_value,
    output logic [XLEN-1:0]            ret_target
);

    localparam int HI_W = XLEN - ALIGN_BITS;
    localparam logic [XLEN-1:0] VEC_OFF_V = XLEN'(VEC_OFFSET);

    typedef struct packed {
        logic [HI_W-1:0] base_hi;
        logic [XLEN-1:0] epc;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_we) begin
            st_d.base_hi = base_hi_wdata;
        end
        if (take) begin
            st_d.epc = next_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Base low bits are hard zero, so OR-ing the offset cannot carry.
    assign base       = {st_q.base_hi, {ALIGN_BITS{1'b0}}};
    assign target     = base | VEC_OFF_V;
    assign epc_value  = next_pc;
    assign ret_target = st_q.epc;

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 8,
    parameter int VEC_OFFSET = 'hC0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 csr_we,
    input  logic [1:0]           csr_sel,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic [XLEN-1:0]      next_pc,
    input  logic                 eret,
    output logic                 take_irq,
    output logic [XLEN-1:0]      take_target,
    output logic [XLEN-1:0]      epc_value,
    output logic [XLEN-1:0]      ret_target
);

    logic [NUM_LINES-1:0] pend_w;
    logic [NUM_LINES-1:0] mask_w;
    logic                 hit_w;
    logic                 gie_w;
    logic                 saved_w;
    logic [XLEN-1:0]      base_w;
    logic                 we_pend, we_mask, we_ctrl, we_base;

    assign we_pend = csr_we && (csr_sel == SEL_PEND);
    assign we_mask = csr_we && (csr_sel == SEL_MASK);
    assign we_ctrl = csr_we && (csr_sel == SEL_CTRL);
    assign we_base = csr_we && (csr_sel == SEL_BASE);

    irq_pend_bank #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .clr_we   (we_pend),
        .clr_bits (csr_wdata[NUM_LINES-1:0]),
        .pend     (pend_w)
    );

    irq_gate #(.NUM_LINES(NUM_LINES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (we_mask),
        .mask_wdata (csr_wdata[NUM_LINES-1:0]),
        .pend       (pend_w),
        .mask       (mask_w),
        .hit_any    (hit_w)
    );

    irq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_any    (hit_w),
        .ctrl_we    (we_ctrl),
        .ctrl_wdata (csr_wdata[1:0]),
        .eret       (eret),
        .take       (take_irq),
        .gie        (gie_w),
        .saved      (saved_w)
    );

    irq_addr_gen #(
        .XLEN       (XLEN),
        .ALIGN_BITS (ALIGN_BITS),
        .VEC_OFFSET (VEC_OFFSET)
    ) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_we       (we_base),
        .base_hi_wdata (csr_wdata[XLEN-1:ALIGN_BITS]),
        .take          (take_irq),
        .next_pc       (next_pc),
        .base          (base_w),
        .target        (take_target),
        .epc_value     (epc_value),
        .ret_target    (ret_target)
    );

    always_comb begin
        csr_rdata = '0;
        case (csr_sel)
            SEL_PEND: csr_rdata[NUM_LINES-1:0] = pend_w;
            SEL_MASK: csr_rdata[NUM_LINES-1:0] = mask_w;
            SEL_CTRL: begin
                csr_rdata[CTRL_GIE_BIT]   = gie_w;
                csr_rdata[CTRL_SAVED_BIT] = saved_w;
            end
            default:  csr_rdata = base_w;
        endcase
    end

endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk #(
    parameter int NUM_LINES  = 32,
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] pend,
    input logic                 take,
    input logic                 gie,
    input logic                 saved,
    input logic                 eret,
    input logic [XLEN-1:0]      next_pc,
    input logic [XLEN-1:0]      ret_target,
    input logic [XLEN-1:0]      base
);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(irq_req)) == $past(irq_req))); // R1

    AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !take); // R7

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R7

    AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!gie && saved)); // R4

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ret_target == $past(next_pc))); // R6

    AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take) |=> (gie == $past(saved) && saved == $past(saved))); // R8

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        base[ALIGN_BITS-1:0] == '0); // R5

endmodule

bind irq_entry_unit irq_entry_unit_chk #(
    .NUM_LINES  (NUM_LINES),
    .XLEN       (XLEN),
    .ALIGN_BITS (ALIGN_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .pend       (pend_w),
    .take       (take_irq),
    .gie        (gie_w),
    .saved      (saved_w),
    .eret       (eret),
    .next_pc    (next_pc),
    .ret_target (ret_target),
    .base       (base_w)
);

// File: tb/irq_entry_unit_test.sv
module irq_entry_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] next_pc = '0;
    logic        eret = 1'b0;
    logic        take_irq;
    logic [31:0] take_target;
    logic [31:0] epc_value;
    logic [31:0] ret_target;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_entry_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .csr_we      (csr_we),
        .csr_sel     (csr_sel),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .next_pc     (next_pc),
        .eret        (eret),
        .take_irq    (take_irq),
        .take_target (take_target),
        .epc_value   (epc_value),
        .ret_target  (ret_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
        csr_sel = sel;
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic pulse_req(input logic [31:0] lines);
        @(negedge clk); irq_req = lines;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic t_reset;
        csr_chk(2'd0, 32'h0, "R9 pending");
        csr_chk(2'd1, 32'h0, "R9 mask");
        csr_chk(2'd2, 32'h0, "R9 control");
        csr_chk(2'd3, 32'h0, "R9 base");
        check("R9 ret_target", ret_target, 32'h0);
        check("R9 take", {31'h0, take_irq}, 32'h0);
    endtask

    task automatic t_pending;
        pulse_req(32'h0000_0020);
        csr_chk(2'd0, 32'h0000_0020, "R1 sticky bit 5");
        pulse_req(32'h8000_0001);
        csr_chk(2'd0, 32'h8000_0021, "R1 accumulate");
        csr_wr(2'd1, 32'hF0F0_1234);
        csr_chk(2'd1, 32'hF0F0_1234, "R10 mask readback");
        csr_wr(2'd1, 32'h0);
        csr_chk(2'd1, 32'h0, "R10 mask cleared");
    endtask

    task automatic t_w1c;
        csr_wr(2'd0, 32'h0000_0000);
        csr_chk(2'd0, 32'h8000_0021, "R2 zero write keeps bits");
        csr_wr(2'd0, 32'h0000_0020);
        csr_chk(2'd0, 32'h8000_0001, "R2 clears only bit 5");
        @(negedge clk);
        irq_req = 32'h0000_0080;
        csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 32'h8000_0081;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0; irq_req = '0;
        csr_chk(2'd0, 32'h0000_0080, "R2 set wins over clear");
        csr_wr(2'd0, 32'hFFFF_FFFF);
        csr_chk(2'd0, 32'h0, "R2 clear all");
    endtask

    task automatic t_base;
        csr_wr(2'd3, 32'h1234_56FF);
        csr_chk(2'd3, 32'h1234_5600, "R5 base low byte zero");
        #1;
        check("R5 target", take_target, 32'h1234_56C0);
    endtask

    task automatic t_take;
        next_pc = 32'h4000_0104;
        csr_wr(2'd1, 32'h0000_0008);
        pulse_req(32'h0000_0208);
        #1;
        check("R7 no take while gie clear", {31'h0, take_irq}, 32'h0);
        csr_wr(2'd2, 32'h0000_0001);
        #1;
        check("R3 take raised", {31'h0, take_irq}, 32'h1);
        check("R6 epc_value", epc_value, 32'h4000_0104);
        check("R5 target at take", take_target, 32'h1234_56C0);
        @(negedge clk);
        next_pc = 32'h0000_0BAD;
        #1;
        check("R7 one-cycle take", {31'h0, take_irq}, 32'h0);
        csr_chk(2'd2, 32'h0000_0002, "R4 gie cleared saved set");
        check("R6 ret_target", ret_target, 32'h4000_0104);
        @(negedge clk);
        #1;
        check("R7 still no nest", {31'h0, take_irq}, 32'h0);
        csr_wr(2'd0, 32'h0000_0008);
        @(negedge clk); eret = 1'b1;
        @(negedge clk); eret = 1'b0;
        csr_chk(2'd2, 32'h0000_0003, "R8 gie restored");
        #1;
        check("R3 masked line 9 no take", {31'h0, take_irq}, 32'h0);
        csr_chk(2'd0, 32'h0000_0200, "R3 line 9 still pending");
        csr_wr(2'd2, 32'h0000_0000);
        @(negedge clk); eret = 1'b1;
        @(negedge clk); eret = 1'b0;
        csr_chk(2'd2, 32'h0000_0000, "R8 restore from cleared saved");
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_w1c();
        t_base();
        t_take();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule